// File: doc/BRIEF.md
# Composite Clock AMI Decoder

This block takes a bipolar composite timing clock, delivered as two digital rails (one for positive marks and one for negative marks), and samples it with a fast system clock. It turns the rails into a stream of qualified marks at the 64 kHz bit rate. It finds the deliberate same-polarity marks that fall on every eighth bit, and from them it produces an 8 kHz frame strobe and a half-duty 8 kHz frame clock. These drive the downstream loop directly, with no division in between. A configuration input enables a further 400 Hz layer. In that mode the frame-marking polarity violation is left out once in every twenty frames, and the block emits a one-cycle superframe marker at the frame that comes after the omission.

Any departure from the expected structure sets a sticky violation status bit. Departures include a misplaced violation, a missing violation, an omission at the wrong spacing, both rails high together, and a loss of marks. The status bit stays set until a clear strobe removes it. The interrupt output is the status bit gated by a mask register, and the mask resets to cleared. After reset, after any structure error and after a loss, the tracker acquires frame phase again from the next polarity violation. When the 400 Hz layer is enabled, it also acquires superframe phase again from the next omission.

Top module: `ami_cc_decoder`

## Requirements
- R1: A mark is accepted only when exactly one rail has been high for at least `cfg_min_width` consecutive samples (a value of 0 acts as 1). `mark_stb` pulses once per accepted mark, and shorter pulses produce no `mark_stb`.
- R2: Both rails high in the same sample sets `viol_sts`.
- R3: Once locked, every mark that repeats the previous mark's polarity and falls 8 marks after the previous frame boundary gives one `frame_stb` pulse. A clean stream of N frames yields N-1 pulses, because the first frame serves for acquisition.
- R4: A same-polarity mark that arrives before the 8th mark of a frame sets `viol_sts`.
- R5: With `cfg_sf_en` low, a frame boundary that has no polarity violation sets `viol_sts`.
- R6: With `cfg_sf_en` high, one omitted violation is accepted while superframe phase is unknown. After that, an omission is accepted only at the 20th frame after the previous omission. An omission anywhere else sets `viol_sts`, and so does a violation present where the omission is due. An accepted omission still gives a `frame_stb`.
- R7: `sf_mark` pulses for one cycle, together with `frame_stb`, at the first real violation after each accepted omission.
- R8: If no mark arrives for 2 bit periods after a mark, `los` rises and `viol_sts` is set. `frame_clk` stays low while `los` is high.
- R9: `frame_clk` rises the cycle after `frame_stb` and stays high for 4 bit periods.
- R10: `viol_sts` stays set until a `viol_clr` pulse arrives. A new error in the same cycle as the clear takes priority over the clear.
- R11: `irq` equals `viol_sts` AND the mask bit. The mask bit resets to 0 and is loaded from `mask_din` when `mask_we` is high.
- R12: After reset, `mark_stb`, `frame_stb`, `frame_clk`, `sf_mark`, `los`, `viol_sts` and `irq` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rail_p | input | 1 | Positive-mark rail (asynchronous) |
| rail_n | input | 1 | Negative-mark rail (asynchronous) |
| cfg_sf_en | input | 1 | Expect the 400 Hz omission pattern |
| cfg_min_width | input | WIDTH_W | Minimum mark width in samples |
| mask_we | input | 1 | Load strobe for the interrupt mask |
| mask_din | input | 1 | Interrupt mask value to load |
| viol_clr | input | 1 | Clear strobe for the violation status |
| mark_stb | output | 1 | One-cycle pulse per accepted mark |
| frame_stb | output | 1 | One-cycle pulse per frame boundary |
| frame_clk | output | 1 | Recovered 8 kHz frame clock |
| sf_mark | output | 1 | One-cycle 400 Hz superframe marker |
| los | output | 1 | Loss of marks |
| viol_sts | output | 1 | Sticky structure violation status |
| irq | output | 1 | Masked violation interrupt |

## Verification
The assertions check several properties on every cycle. Back-to-back marks must differ in polarity. A frame strobe only follows an accepted mark. The superframe marker is a single pulse that coincides with a frame strobe. The status bit holds until it is cleared, and a both-rails error always reaches it. The frame clock stays low during a loss. Only the bench scenarios can show whether the tracker counts marks and frames correctly. Those scenarios cover the number of frame strobes, the rejection of extra, missing and misplaced omissions, the acceptance of the twenty-frame spacing, the rejection of narrow glitches, the frame clock duty, and the gating by the mask.

// File: rtl/ami_cc_pkg.sv
// Shared constants and types for the composite clock AMI decoder.
// Assumes the standard composite structure: 8 marks per frame and
// 20 frames per superframe.
package ami_cc_pkg;
    localparam int MARKS_PER_FRAME = 8;
    localparam int FRAMES_PER_SF   = 20;

    // One qualified mark event from the rail front end.
    typedef struct packed {
        logic valid;   // one-cycle strobe
        logic pos;     // 1 = positive rail, 0 = negative rail
    } mark_t;
endpackage

// File: rtl/ami_cc_mark_detect.sv
// Rail front end. Synchronises both rails with two flops each and
// qualifies a mark when exactly one rail stays high for min_width
// samples, emitting one event per mark. Flags both rails high at once.
// Assumes the rails are asynchronous to clk.
module ami_cc_mark_detect
    import ami_cc_pkg::*;
#(
    parameter int WIDTH_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rail_p,
    input  logic               rail_n,
    input  logic [WIDTH_W-1:0] min_width,
    output mark_t              mark,
    output logic               both_err
);
    logic [1:0]         sync_p, sync_n;
    logic               sp, sn, single, same_run, fire, both_d;
    logic               run_pol, fired;
    logic [WIDTH_W-1:0] run_len, run_next, thr;

    assign sp = sync_p[1];
    assign sn = sync_n[1];

    // Two-flop synchronisers on both rails.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_p <= '0;
            sync_n <= '0;
        end else begin
            sync_p <= {sync_p[0], rail_p};
            sync_n <= {sync_n[0], rail_n};
        end
    end

    // Run length of the current single-rail pulse and the firing decision.
    always_comb begin
        single   = sp ^ sn;
        thr      = (min_width == '0) ? WIDTH_W'(1) : min_width;
        same_run = single && (run_len != '0) && (run_pol == sp);
        if (same_run)
            run_next = (run_len == '1) ? run_len : run_len + WIDTH_W'(1);
        else if (single)
            run_next = WIDTH_W'(1);
        else
            run_next = '0;
        fire = single && (run_next >= thr) && !(same_run && fired);
    end

    // Run state, the mark event register and the both-rails edge detector.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_len  <= '0;
            run_pol  <= 1'b0;
            fired    <= 1'b0;
            mark     <= '0;
            both_d   <= 1'b0;
            both_err <= 1'b0;
        end else begin
            run_len    <= run_next;
            run_pol    <= single ? sp : run_pol;
            fired      <= single && (fire || (same_run && fired));
            mark.valid <= fire;
            mark.pos   <= sp;
            both_d     <= sp & sn;
            both_err   <= sp & sn & ~both_d;
        end
    end

    AST_MARK_ALTERNATE_RAIL: assert property (@(posedge clk) disable iff (!rst_n)
        mark.valid && $past(mark.valid) |-> mark.pos != $past(mark.pos)); // R1
endmodule

// File: rtl/ami_cc_loss_mon.sv
// Loss monitor. Arms on the first mark and raises los after LOSS_CYC
// cycles with no mark, giving a one-cycle loss_err on entry. A new
// mark clears los. Assumes marks arrive as one-cycle strobes.
module ami_cc_loss_mon #(
    parameter int LOSS_CYC = 7812
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mark_valid,
    output logic los,
    output logic loss_err
);
    localparam int GAP_W = $clog2(LOSS_CYC + 1);

    logic [GAP_W-1:0] gap;
    logic             armed;

    // Gap counter since the last mark, with loss entry detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap      <= '0;
            armed    <= 1'b0;
            los      <= 1'b0;
            loss_err <= 1'b0;
        end else begin
            loss_err <= 1'b0;
            if (mark_valid) begin
                gap   <= '0;
                armed <= 1'b1;
                los   <= 1'b0;
            end else if (armed && !los) begin
                if (gap == GAP_W'(LOSS_CYC - 1)) begin
                    los      <= 1'b1;
                    loss_err <= 1'b1;
                end else begin
                    gap <= gap + GAP_W'(1);
                end
            end
        end
    end

    AST_LOS_AFTER_SILENCE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(los) |-> !$past(mark_valid)); // R8
endmodule

// File: rtl/ami_cc_frame_track.sv
// Frame and superframe tracker. Acquires frame phase from a polarity
// violation, then expects one on every MARKS-th mark. When sf_en is
// high, it accepts one omission per SF_LEN frames, learning the phase
// from the first omission. Every departure pulses struct_err and
// forces reacquisition. Assumes the marks are already qualified.
module ami_cc_frame_track
    import ami_cc_pkg::*;
#(
    parameter int MARKS  = MARKS_PER_FRAME,
    parameter int SF_LEN = FRAMES_PER_SF
) (
    input  logic  clk,
    input  logic  rst_n,
    input  mark_t mark,
    input  logic  resync,
    input  logic  sf_en,
    output logic  frame_stb,
    output logic  sf_mark,
    output logic  struct_err
);
    localparam int MCNT_W  = $clog2(MARKS);
    localparam int SFCNT_W = $clog2(SF_LEN);

    logic               have_prev, prev_pos, locked, sf_locked, sf_pend;
    logic [MCNT_W-1:0]  mcnt;
    logic [SFCNT_W-1:0] sf_cnt;
    logic               bpv, slot, sf_due;

    // Classification of the incoming mark against the tracked phase.
    always_comb begin
        bpv    = have_prev && (mark.pos == prev_pos);
        slot   = locked && (mcnt == MCNT_W'(MARKS - 1));
        sf_due = sf_cnt == SFCNT_W'(SF_LEN - 1);
    end

    // Frame/superframe state machine, one decision per accepted mark.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            have_prev  <= 1'b0;
            prev_pos   <= 1'b0;
            locked     <= 1'b0;
            sf_locked  <= 1'b0;
            sf_pend    <= 1'b0;
            mcnt       <= '0;
            sf_cnt     <= '0;
            frame_stb  <= 1'b0;
            sf_mark    <= 1'b0;
            struct_err <= 1'b0;
        end else begin
            frame_stb  <= 1'b0;
            sf_mark    <= 1'b0;
            struct_err <= 1'b0;
            if (!sf_en) begin
                sf_locked <= 1'b0;
                sf_pend   <= 1'b0;
            end
            if (resync) begin
                have_prev <= 1'b0;
                locked    <= 1'b0;
                sf_locked <= 1'b0;
                sf_pend   <= 1'b0;
                mcnt      <= '0;
            end else if (mark.valid) begin
                have_prev <= 1'b1;
                prev_pos  <= mark.pos;
                if (!have_prev) begin
                    // first mark only sets the polarity reference
                end else if (!locked) begin
                    if (bpv) begin
                        locked    <= 1'b1;
                        mcnt      <= '0;
                        frame_stb <= 1'b1;
                    end
                end else if (!slot) begin
                    if (bpv) begin
                        struct_err <= 1'b1;
                        locked     <= 1'b0;
                        sf_locked  <= 1'b0;
                        sf_pend    <= 1'b0;
                    end else begin
                        mcnt <= mcnt + MCNT_W'(1);
                    end
                end else if (bpv) begin
                    if (sf_en && sf_locked && sf_due) begin
                        struct_err <= 1'b1;
                        locked     <= 1'b0;
                        sf_locked  <= 1'b0;
                        sf_pend    <= 1'b0;
                    end else begin
                        mcnt      <= '0;
                        frame_stb <= 1'b1;
                        if (!sf_due)
                            sf_cnt <= sf_cnt + SFCNT_W'(1);
                        if (sf_pend) begin
                            sf_mark <= 1'b1;
                            sf_pend <= 1'b0;
                        end
                    end
                end else begin
                    if (sf_en && (!sf_locked || sf_due)) begin
                        mcnt      <= '0;
                        frame_stb <= 1'b1;
                        sf_locked <= 1'b1;
                        sf_cnt    <= '0;
                        sf_pend   <= 1'b1;
                    end else begin
                        struct_err <= 1'b1;
                        locked     <= 1'b0;
                        sf_locked  <= 1'b0;
                        sf_pend    <= 1'b0;
                    end
                end
            end
        end
    end

    AST_FRAME_FROM_MARK: assert property (@(posedge clk) disable iff (!rst_n)
        frame_stb |-> $past(mark.valid)); // R3
    AST_SF_WITH_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        sf_mark |-> frame_stb); // R7
    AST_SF_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        sf_mark |=> !sf_mark); // R7
endmodule

// File: rtl/ami_cc_decoder.sv
// Top of the composite clock AMI decoder. Wires the rail front end,
// the loss monitor and the frame tracker together. It also holds the
// sticky violation status, the interrupt mask and the half-duty 8 kHz
// frame clock generator. BIT_CYC is the number of system clocks per
// 64 kHz bit.
module ami_cc_decoder
    import ami_cc_pkg::*;
#(
    parameter int BIT_CYC = 3906,
    parameter int WIDTH_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rail_p,
    input  logic               rail_n,
    input  logic               cfg_sf_en,
    input  logic [WIDTH_W-1:0] cfg_min_width,
    input  logic               mask_we,
    input  logic               mask_din,
    input  logic               viol_clr,
    output logic               mark_stb,
    output logic               frame_stb,
    output logic               frame_clk,
    output logic               sf_mark,
    output logic               los,
    output logic               viol_sts,
    output logic               irq
);
    localparam int LOSS_CYC = 2 * BIT_CYC;
    localparam int HALF_CYC = (MARKS_PER_FRAME / 2) * BIT_CYC;
    localparam int HI_W     = $clog2(HALF_CYC + 1);

    mark_t         mark;
    logic          both_err, loss_err, struct_err, any_err, mask_q;
    logic [HI_W-1:0] hi_cnt;

    ami_cc_mark_detect #(.WIDTH_W(WIDTH_W)) u_detect (
        .clk      (clk),
        .rst_n    (rst_n),
        .rail_p   (rail_p),
        .rail_n   (rail_n),
        .min_width(cfg_min_width),
        .mark     (mark),
        .both_err (both_err)
    );

    ami_cc_loss_mon #(.LOSS_CYC(LOSS_CYC)) u_loss (
        .clk       (clk),
        .rst_n     (rst_n),
        .mark_valid(mark.valid),
        .los       (los),
        .loss_err  (loss_err)
    );

    ami_cc_frame_track #(
        .MARKS (MARKS_PER_FRAME),
        .SF_LEN(FRAMES_PER_SF)
    ) u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .mark      (mark),
        .resync    (loss_err),
        .sf_en     (cfg_sf_en),
        .frame_stb (frame_stb),
        .sf_mark   (sf_mark),
        .struct_err(struct_err)
    );

    assign mark_stb = mark.valid;
    assign any_err  = both_err | loss_err | struct_err;
    assign irq      = viol_sts & mask_q;

    // Sticky violation status; a new error outranks the clear strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            viol_sts <= 1'b0;
        else if (any_err)
            viol_sts <= 1'b1;
        else if (viol_clr)
            viol_sts <= 1'b0;
    end

    // Interrupt mask register, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mask_q <= 1'b0;
        else if (mask_we)
            mask_q <= mask_din;
    end

    // Half-duty frame clock: high for HALF_CYC cycles after each frame strobe.
    always_ff @(posedge clk) begin
        if (!rst_n || los) begin
            hi_cnt    <= '0;
            frame_clk <= 1'b0;
        end else if (frame_stb) begin
            hi_cnt    <= HI_W'(HALF_CYC - 1);
            frame_clk <= 1'b1;
        end else if (hi_cnt != '0) begin
            hi_cnt <= hi_cnt - HI_W'(1);
        end else begin
            frame_clk <= 1'b0;
        end
    end

    AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        $past(viol_sts) && !$past(viol_clr) |-> viol_sts); // R10
    AST_BOTH_RAILS_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        $past(both_err) |-> viol_sts); // R2
    AST_LOSS_FRAME_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        los && $past(los) |-> !frame_clk); // R8
endmodule

// File: tb/ami_cc_decoder_bench.sv
`timescale 1ns/1ps
module ami_cc_decoder_bench;
    localparam int BIT = 16;
    localparam int MW  = 4;

    logic       clk = 1'b0, rst_n = 1'b0;
    logic       rail_p = 1'b0, rail_n = 1'b0, cfg_sf_en = 1'b0;
    logic [7:0] cfg_min_width = 8'(MW);
    logic       mask_we = 1'b0, mask_din = 1'b0, viol_clr = 1'b0;
    logic       mark_stb, frame_stb, frame_clk, sf_mark, los, viol_sts, irq;

    int  n_chk = 0, n_bad = 0;
    int  n_mark = 0, n_frame = 0, n_sf = 0;
    logic cnt_clr = 1'b0;
    bit  done = 1'b0;

    always #2 clk = ~clk;

    ami_cc_decoder #(.BIT_CYC(BIT), .WIDTH_W(8)) u_ami_cc_decoder (
        .clk(clk), .rst_n(rst_n), .rail_p(rail_p), .rail_n(rail_n),
        .cfg_sf_en(cfg_sf_en), .cfg_min_width(cfg_min_width),
        .mask_we(mask_we), .mask_din(mask_din), .viol_clr(viol_clr),
        .mark_stb(mark_stb), .frame_stb(frame_stb), .frame_clk(frame_clk),
        .sf_mark(sf_mark), .los(los), .viol_sts(viol_sts), .irq(irq)
    );

    // Event counters, sampled away from the active edge.
    always @(negedge clk) begin
        if (cnt_clr) begin
            n_mark = 0; n_frame = 0; n_sf = 0;
        end else if (rst_n) begin
            if (mark_stb)  n_mark++;
            if (frame_stb) n_frame++;
            if (sf_mark)   n_sf++;
        end
    end

    typedef struct packed {
        logic       sf;
        logic [7:0] nfr, oa, ob, ex;
        logic       ev;
        logic [7:0] efr, esf;   // 255 = not checked
    } vec_t;

    localparam vec_t VECS [7] = '{
        '{1'b0, 8'd12, 8'd0,  8'd0,  8'd0, 1'b0, 8'd11,  8'd0},   // clean
        '{1'b0, 8'd12, 8'd0,  8'd0,  8'd5, 1'b1, 8'd255, 8'd255}, // extra violation
        '{1'b0, 8'd12, 8'd6,  8'd0,  8'd0, 1'b1, 8'd255, 8'd255}, // omission, sf off
        '{1'b1, 8'd45, 8'd10, 8'd30, 8'd0, 1'b0, 8'd44,  8'd2},   // 20-frame spacing
        '{1'b1, 8'd45, 8'd10, 8'd29, 8'd0, 1'b1, 8'd255, 8'd255}, // early omission
        '{1'b1, 8'd35, 8'd10, 8'd0,  8'd0, 1'b1, 8'd255, 8'd255}, // missing omission
        '{1'b1, 8'd12, 8'd0,  8'd0,  8'd0, 1'b0, 8'd11,  8'd0}    // sf on, not yet locked
    };

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; tick(4); rst_n = 1'b1; tick(1);
        cnt_clr = 1'b1; tick(1); cnt_clr = 1'b0;
    endtask

    task automatic send_mark(input bit pos, input int w);
        rail_p = pos; rail_n = !pos; tick(w);
        rail_p = 1'b0; rail_n = 1'b0; tick(BIT - w);
    endtask

    task automatic send_stream(input int nfr, input int oa, input int ob, input int ex);
        bit last = 1'b0;
        for (int f = 0; f < nfr; f++) begin
            for (int m = 0; m < 8; m++) begin
                bit v, p;
                v = (m == 0 && f != 0 && f != oa && f != ob) || (ex != 0 && f == ex && m == 3);
                p = (f == 0 && m == 0) ? 1'b1 : (v ? last : !last);
                send_mark(p, 8);
                last = p;
            end
        end
    endtask

    function automatic string row_tag(input vec_t v);
        if (v.sf)      return "R6";
        if (v.ex != 0) return "R4";
        if (v.oa != 0) return "R5";
        return "R3";
    endfunction

    initial begin
        // Reset state (R12, R11 default mask).
        do_reset();
        check({mark_stb, frame_stb, frame_clk, sf_mark, los, viol_sts, irq} == 7'b0,
              "R12 reset outputs", {mark_stb, frame_stb, frame_clk, sf_mark, los, viol_sts, irq}, 0);

        // Vector table of composite streams.
        for (int i = 0; i < 7; i++) begin
            vec_t v;
            v = VECS[i];
            do_reset();
            cfg_sf_en = v.sf;
            tick(2);
            send_stream(int'(v.nfr), int'(v.oa), int'(v.ob), int'(v.ex));
            tick(2);
            check(viol_sts == v.ev, row_tag(v), viol_sts, v.ev);
            if (v.efr != 8'd255)
                check(n_frame == int'(v.efr), "R3 frame count", n_frame, v.efr);
            if (v.esf != 8'd255)
                check(n_sf == int'(v.esf), "R7 superframe marks", n_sf, v.esf);
        end
        cfg_sf_en = 1'b0;

        // R1: narrow glitch ignored, full-width mark accepted.
        do_reset();
        rail_p = 1'b1; tick(MW - 2); rail_p = 1'b0; tick(10);
        check(n_mark == 0, "R1 glitch rejected", n_mark, 0);
        send_mark(1'b0, 8);
        check(n_mark == 1, "R1 mark accepted", n_mark, 1);

        // R8: silence after a mark raises los and the status.
        tick(3 * BIT);
        check(los == 1'b1, "R8 los", los, 1);
        check(viol_sts == 1'b1, "R8 loss status", viol_sts, 1);

        // R10: status holds, then clears on the strobe.
        tick(20);
        check(viol_sts == 1'b1, "R10 sticky", viol_sts, 1);
        viol_clr = 1'b1; tick(1); viol_clr = 1'b0; tick(2);
        check(viol_sts == 1'b0, "R10 cleared", viol_sts, 0);

        // R2: both rails high sets the status; R11 gating by mask.
        rail_p = 1'b1; rail_n = 1'b1; tick(6); rail_p = 1'b0; rail_n = 1'b0; tick(4);
        check(viol_sts == 1'b1, "R2 both rails", viol_sts, 1);
        check(irq == 1'b0, "R11 masked by default", irq, 0);
        mask_din = 1'b1; mask_we = 1'b1; tick(1); mask_we = 1'b0; tick(1);
        check(irq == 1'b1, "R11 unmasked", irq, 1);
        mask_din = 1'b0; mask_we = 1'b1; tick(1); mask_we = 1'b0; tick(1);
        check(irq == 1'b0, "R11 remasked", irq, 0);

        // R9: frame clock duty; R8: held low during a loss.
        do_reset();
        fork
            send_stream(4, 0, 0, 0);
            begin
                while (!frame_stb) tick(1);
                tick(2 * BIT);
                check(frame_clk == 1'b1, "R9 frame_clk high", frame_clk, 1);
                tick(4 * BIT);
                check(frame_clk == 1'b0, "R9 frame_clk low", frame_clk, 0);
            end
        join
        tick(3 * BIT);
        check(los == 1'b1 && frame_clk == 1'b0, "R8 frame_clk low on loss", frame_clk, 0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule